// File: doc/BRIEF.md
# External Protection FET Override Controller

This block sits between the software-visible FET control bits of a battery pack controller and the analog FET drivers. Software sets three control bits through a small register interface: charge FET on, discharge FET on, and deep-undervoltage recovery mode on. An active-high external protection pin can drive both FET enables low and hold recovery mode off. This path is purely combinational, so it acts without waiting for a clock edge. The stored software bits are never changed by the pin. When the pin falls, each output follows its software bit again at once.

The feature is enabled by reset. While it is enabled, the block tells the port logic to treat the pin as a digital input. The pin state can be read as synchronized status, and any edge of the pin raises a sticky interrupt flag. Software may switch the feature off only until it sets a lock bit. Only reset clears the lock.

Registers are selected by a 2-bit address and carry 3 data bits. Address 0 is configuration: bit 0 is the feature enable and bit 1 is the lock. Address 1 is interrupt: bit 0 is the interrupt enable and bit 1 is the flag. Address 2 is status: bit 0 is the pin state. Address 3 holds the software FET bits: bit 0 is charge, bit 1 is discharge and bit 2 is recovery.

Top module: `ext_prot_ctrl`

## Requirements
- R1: While the feature is enabled and `prot_pin` is 1, `chg_fet_en` and `dis_fet_en` are 0 in the same time step, before any clock edge.
- R2: While the feature is enabled and `prot_pin` is 1, `recov_en` is 0.
- R3: The software bits at address 3 change only when address 3 is written. A protection event leaves them as they were, and reading address 3 returns them.
- R4: While `prot_pin` is 0, `chg_fet_en`, `dis_fet_en` and `recov_en` equal address-3 bits 0, 1 and 2 in the same time step.
- R5: Reset sets the feature enable to 1, clears the lock, the interrupt enable, the flag and the software bits. `pin_override` is 1 while `rst` is high and whenever the feature is enabled.
- R6: Writing 1 to address-0 bit 1 sets the lock. Only reset clears the lock. A write to address-0 bit 0 changes the feature enable only if the lock was clear before that write.
- R7: Address-2 bit 0 reads the pin after SYNC_STAGES clock edges while the feature is enabled, and reads 0 while it is disabled.
- R8: A change of the synchronized pin while the feature is enabled sets the flag at address-1 bit 1. The flag stays set until a write of 1 to that bit clears it. A new edge in the same cycle as the clear wins.
- R9: `irq` is 1 exactly when both the flag and the interrupt enable (address-1 bit 0) are 1.
- R10: While the feature is disabled, `pin_override` is 0 (outside reset), the pin has no effect on the FET outputs, and pin edges do not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_pin | input | 1 | Raw external protection pin, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 3 | Register write data |
| reg_rdata | output | 3 | Register read data for `reg_addr`, combinational |
| chg_fet_en | output | 1 | Charge FET enable to driver |
| dis_fet_en | output | 1 | Discharge FET enable to driver |
| recov_en | output | 1 | Deep-undervoltage recovery mode enable |
| pin_override | output | 1 | Forces the port pin to act as a digital input |
| irq | output | 1 | Any-edge protection interrupt request |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. A latency mistake that only holds for two stages then shows up as a status or flag timing mismatch against the queue-based model. The forced-off path is also checked one time step after the pin rises, with no clock edge between, to confirm that the path is combinational. A one-cycle pulse on the pin checks both the override release and that a single pulse produces edges the flag captures.

// File: rtl/ext_prot_pkg.sv
package ext_prot_pkg;

    localparam int REG_AW = 2;
    localparam int REG_DW = 3;

    typedef enum logic [REG_AW-1:0] {
        REG_CFG  = 2'd0,
        REG_IRQ  = 2'd1,
        REG_STAT = 2'd2,
        REG_SWC  = 2'd3
    } reg_sel_e;

    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_LOCK_BIT = 1;
    localparam int IRQ_IE_BIT   = 0;
    localparam int IRQ_FLAG_BIT = 1;

    typedef struct packed {
        logic recov;
        logic dis;
        logic chg;
    } sw_ctrl_t;

    typedef struct packed {
        logic chg;
        logic dis;
        logic recov;
    } fet_drv_t;

    function automatic fet_drv_t gate_fets(sw_ctrl_t sw, logic force_off);
        fet_drv_t d;
        d.chg   = sw.chg   & ~force_off;
        d.dis   = sw.dis   & ~force_off;
        d.recov = sw.recov & ~force_off;
        return d;
    endfunction

endpackage

// File: rtl/ext_prot_sync.sv
module ext_prot_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_raw,
    input  logic active,
    output logic pin_sync,
    output logic edge_pulse
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pin_raw;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], pin_raw};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain[STAGES-1];
    end

    assign pin_sync   = chain[STAGES-1];
    assign edge_pulse = active & (chain[STAGES-1] ^ prev_q);
endmodule

// File: rtl/ext_prot_regs.sv
module ext_prot_regs
    import ext_prot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  reg_sel_e          reg_sel,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic              edge_pulse,
    output logic              feat_en,
    output logic              cfg_lock,
    output logic              irq_ie,
    output logic              irq_flag,
    output sw_ctrl_t          sw_ctrl
);
    logic wr_cfg, wr_irq, wr_swc;

    assign wr_cfg = reg_wr && (reg_sel == REG_CFG);
    assign wr_irq = reg_wr && (reg_sel == REG_IRQ);
    assign wr_swc = reg_wr && (reg_sel == REG_SWC);

    always_ff @(posedge clk) begin
        if (rst) begin
            feat_en  <= 1'b1;
            cfg_lock <= 1'b0;
            irq_ie   <= 1'b0;
            irq_flag <= 1'b0;
            sw_ctrl  <= '0;
        end else begin
            if (wr_cfg) begin
                if (!cfg_lock) feat_en <= reg_wdata[CFG_EN_BIT];
                if (reg_wdata[CFG_LOCK_BIT]) cfg_lock <= 1'b1;
            end
            if (wr_irq) irq_ie <= reg_wdata[IRQ_IE_BIT];
            if (edge_pulse)
                irq_flag <= 1'b1;
            else if (wr_irq && reg_wdata[IRQ_FLAG_BIT])
                irq_flag <= 1'b0;
            if (wr_swc) sw_ctrl <= sw_ctrl_t'(reg_wdata);
        end
    end
endmodule

// File: rtl/ext_prot_gate.sv
module ext_prot_gate
    import ext_prot_pkg::*;
(
    input  logic     rst,
    input  logic     feat_en,
    input  logic     pin_raw,
    input  sw_ctrl_t sw_ctrl,
    output fet_drv_t fet_drv,
    output logic     pin_override
);
    logic force_off;

    assign force_off    = feat_en & pin_raw;
    assign fet_drv      = gate_fets(sw_ctrl, force_off);
    assign pin_override = feat_en | rst;
endmodule

// File: rtl/ext_prot_ctrl.sv
module ext_prot_ctrl
    import ext_prot_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prot_pin,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              chg_fet_en,
    output logic              dis_fet_en,
    output logic              recov_en,
    output logic              pin_override,
    output logic              irq
);
    reg_sel_e reg_sel;
    logic     feat_en, cfg_lock, irq_ie, irq_flag;
    logic     pin_sync, edge_pulse;
    sw_ctrl_t sw_ctrl;
    fet_drv_t fet_drv;

    assign reg_sel = reg_sel_e'(reg_addr);

    ext_prot_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pin_raw    (prot_pin),
        .active     (feat_en),
        .pin_sync   (pin_sync),
        .edge_pulse (edge_pulse)
    );

    ext_prot_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .edge_pulse (edge_pulse),
        .feat_en    (feat_en),
        .cfg_lock   (cfg_lock),
        .irq_ie     (irq_ie),
        .irq_flag   (irq_flag),
        .sw_ctrl    (sw_ctrl)
    );

    ext_prot_gate u_gate (
        .rst          (rst),
        .feat_en      (feat_en),
        .pin_raw      (prot_pin),
        .sw_ctrl      (sw_ctrl),
        .fet_drv      (fet_drv),
        .pin_override (pin_override)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            REG_CFG:  begin
                reg_rdata[CFG_EN_BIT]   = feat_en;
                reg_rdata[CFG_LOCK_BIT] = cfg_lock;
            end
            REG_IRQ:  begin
                reg_rdata[IRQ_IE_BIT]   = irq_ie;
                reg_rdata[IRQ_FLAG_BIT] = irq_flag;
            end
            REG_STAT: reg_rdata[0] = pin_sync & feat_en;
            REG_SWC:  reg_rdata = sw_ctrl;
        endcase
    end

    assign chg_fet_en = fet_drv.chg;
    assign dis_fet_en = fet_drv.dis;
    assign recov_en   = fet_drv.recov;
    assign irq        = irq_flag & irq_ie;
endmodule

// File: rtl/ext_prot_ctrl_chk.sv
module ext_prot_ctrl_chk
    import ext_prot_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     prot_pin,
    input logic     chg_fet_en,
    input logic     dis_fet_en,
    input logic     recov_en,
    input logic     pin_override,
    input logic     irq,
    input logic     feat_en,
    input logic     cfg_lock,
    input logic     irq_ie,
    input logic     irq_flag,
    input sw_ctrl_t sw_ctrl,
    input logic     clr_req,
    input logic     sw_wr
);
    AST_FETS_FORCED_OFF: assert property (@(posedge clk) disable iff (rst)
        (feat_en && prot_pin) |-> (!chg_fet_en && !dis_fet_en)); // R1
    AST_RECOV_SUPPRESSED: assert property (@(posedge clk) disable iff (rst)
        (feat_en && prot_pin) |-> !recov_en); // R2
    AST_SW_BITS_HELD: assert property (@(posedge clk) disable iff (rst)
        !sw_wr |=> $stable(sw_ctrl)); // R3
    AST_FOLLOW_SW: assert property (@(posedge clk) disable iff (rst)
        !prot_pin |-> (chg_fet_en == sw_ctrl.chg && dis_fet_en == sw_ctrl.dis
                       && recov_en == sw_ctrl.recov)); // R4
    AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (rst)
        cfg_lock |=> cfg_lock); // R6
    AST_EN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        cfg_lock |=> $stable(feat_en)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !clr_req) |=> irq_flag); // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_ie && irq_flag)); // R9
    AST_DISABLED_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        !feat_en |-> (!pin_override && chg_fet_en == sw_ctrl.chg
                      && dis_fet_en == sw_ctrl.dis)); // R10
    AST_DISABLED_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!feat_en && !irq_flag) |=> !irq_flag); // R10
endmodule

bind ext_prot_ctrl ext_prot_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .prot_pin     (prot_pin),
    .chg_fet_en   (chg_fet_en),
    .dis_fet_en   (dis_fet_en),
    .recov_en     (recov_en),
    .pin_override (pin_override),
    .irq          (irq),
    .feat_en      (feat_en),
    .cfg_lock     (cfg_lock),
    .irq_ie       (irq_ie),
    .irq_flag     (irq_flag),
    .sw_ctrl      (sw_ctrl),
    .clr_req      (reg_wr && reg_addr == 2'd1 && reg_wdata[1]),
    .sw_wr        (reg_wr && reg_addr == 2'd3)
);

// File: tb/ext_prot_ctrl_tb.sv
module ext_prot_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSYNC      = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prot_pin = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [2:0] reg_wdata = 3'd0;
    logic [2:0] reg_rdata;
    logic       chg_fet_en, dis_fet_en, recov_en, pin_override, irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit started = 1'b0;

    // behavioural reference state
    bit m_en = 1, m_lock = 0, m_ie = 0, m_flag = 0, m_prev = 0;
    bit [2:0] m_sw = 0;
    bit m_sync[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_prot_ctrl #(.SYNC_STAGES(NSYNC)) u_dut (
        .clk(clk), .rst(rst), .prot_pin(prot_pin), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .chg_fet_en(chg_fet_en), .dis_fet_en(dis_fet_en), .recov_en(recov_en),
        .pin_override(pin_override), .irq(irq)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_last();
        return m_sync[NSYNC-1];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 1; m_lock = 0; m_ie = 0; m_flag = 0; m_prev = 0; m_sw = 0;
            m_sync = {};
            for (int i = 0; i < NSYNC; i++) m_sync.push_back(1'b0);
            started = 1'b1;
        end else begin
            bit edge_seen;
            bit old_lock;
            edge_seen = m_en && (m_last() != m_prev);
            old_lock = m_lock;
            m_prev = m_last();
            m_sync.push_front(prot_pin);
            void'(m_sync.pop_back());
            if (edge_seen) m_flag = 1;
            else if (reg_wr && reg_addr == 2'd1 && reg_wdata[1]) m_flag = 0;
            if (reg_wr && reg_addr == 2'd0) begin
                if (!old_lock) m_en = reg_wdata[0];
                if (reg_wdata[1]) m_lock = 1;
            end
            if (reg_wr && reg_addr == 2'd1) m_ie = reg_wdata[0];
            if (reg_wr && reg_addr == 2'd3) m_sw = reg_wdata;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!done && started && !rst) begin
            bit force_off;
            bit [2:0] exp_rd;
            force_off = m_en && prot_pin;
            case (reg_addr)
                2'd0: exp_rd = {1'b0, m_lock, m_en};
                2'd1: exp_rd = {1'b0, m_flag, m_ie};
                2'd2: exp_rd = {2'b0, m_en && m_last()};
                default: exp_rd = m_sw;
            endcase
            check("R1 R4 chg_fet_en", chg_fet_en, m_sw[0] && !force_off);
            check("R1 R4 dis_fet_en", dis_fet_en, m_sw[1] && !force_off);
            check("R2 R4 recov_en", recov_en, m_sw[2] && !force_off);
            check("R5 R10 pin_override", pin_override, m_en);
            check("R9 irq", irq, m_flag && m_ie);
            check("R3 R6 R7 R8 reg_rdata", reg_rdata, exp_rd);
        end
    end

    task automatic wr(logic [1:0] a, logic [2:0] d);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, int exp, string tag);
        @(negedge clk); #1;
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #2;
        check("R5 override during reset", pin_override, 1);
        idle(3);
        check("R5 override during reset", pin_override, 1);
        rst = 1'b0;
        rd(2'd0, 3'b001, "R5 cfg after reset");
        rd(2'd3, 0, "R5 sw bits after reset");

        wr(2'd3, 3'b111);
        idle(1);
        check("R4 chg follows sw", chg_fet_en, 1);
        check("R4 recov follows sw", recov_en, 1);
        wr(2'd1, 3'b001);

        // combinational override, no clock edge in between
        @(negedge clk); #1;
        prot_pin = 1'b1;
        #1;
        check("R1 chg off without clock", chg_fet_en, 0);
        check("R1 dis off without clock", dis_fet_en, 0);
        check("R2 recov off", recov_en, 0);
        idle(NSYNC + 3);
        rd(2'd3, 3'b111, "R3 sw bits unchanged");
        rd(2'd2, 1, "R7 status high");
        check("R8 R9 irq after rise", irq, 1);

        wr(2'd1, 3'b011);
        rd(2'd1, 3'b001, "R8 flag cleared by W1C");
        @(negedge clk); #1;
        prot_pin = 1'b0;
        #1;
        check("R4 chg restored at once", chg_fet_en, 1);
        check("R4 recov resumes", recov_en, 1);
        idle(NSYNC + 3);
        rd(2'd1, 3'b011, "R8 flag on fall edge");
        wr(2'd1, 3'b000);
        check("R9 irq masked", irq, 0);
        rd(2'd1, 3'b010, "R8 flag sticky");

        // one-cycle pulse
        wr(2'd1, 3'b011);
        @(negedge clk); #1;
        prot_pin = 1'b1;
        @(negedge clk); #1;
        prot_pin = 1'b0;
        #1;
        check("R4 release after pulse", dis_fet_en, 1);
        idle(NSYNC + 3);
        check("R8 irq after pulse", irq, 1);
        wr(2'd1, 3'b011);

        // feature disabled
        wr(2'd0, 3'b000);
        check("R10 override off", pin_override, 0);
        @(negedge clk); #1;
        prot_pin = 1'b1;
        #1;
        check("R10 chg unaffected", chg_fet_en, 1);
        idle(NSYNC + 3);
        rd(2'd2, 0, "R7 status zero when disabled");
        rd(2'd1, 3'b001, "R10 no flag when disabled");
        @(negedge clk); #1;
        prot_pin = 1'b0;
        idle(NSYNC + 2);

        // lock
        wr(2'd0, 3'b011);
        wr(2'd0, 3'b000);
        rd(2'd0, 3'b011, "R6 enable frozen by lock");
        wr(2'd0, 3'b001);
        rd(2'd0, 3'b011, "R6 lock stays set");

        @(negedge clk); #1;
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        rd(2'd0, 3'b001, "R5 R6 reset clears lock");
        idle(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule